// File: doc/BRIEF.md
# Set-Point Request Arbiter

This block chooses the operating set point of the system, one of sixteen. A requester presents a set of acceptable set points, the CPU mode it runs in, and the path the request came through (software/run, sleep or wakeup). The arbiter intersects that set with the successor map of the current set point and with the allowed mask of the CPU mode. Among the survivors it picks the one with the highest programmable priority. If nothing survives, no transition starts and a sticky flag for that request path is raised.

An accepted request makes the block busy and hands the chosen target to an external transition sequencer with a one-cycle start pulse. The block then waits for the sequencer's done signal. On completion the previous set point takes the old current value, the current set point takes the target, and busy drops. All configuration arrives on flat ports; no register bus is modelled.

Top module: `sp_arbiter`

## Requirements
- R1: After reset, current, previous and target set point all equal 0, busy is 0, seq_start is 0 and all three flags are 0.
- R2: The allowed set is the AND of the requester's mask, the successor map of the current set point (bits [16*c+15:16*c] of succ_maps for current set point c), and the mask of the requested CPU mode (bits [16*m+15:16*m] of mode_masks, with 0=RUN, 1=WAIT, 2=STOP, 3=SUSPEND).
- R3: Among allowed set points the highest priority wins. The priority of set point i<8 is prio_lo[4*i+3:4*i], and of set point i>=8 it is prio_hi[4*(i-8)+3:4*(i-8)].
- R4: When several allowed set points share the top priority, the lowest index wins.
- R5: A request accepted on a clock edge sets busy and target at that edge, and drives seq_start high for exactly that one following cycle, with seq_target equal to the winner.
- R6: seq_done while busy makes previous take the old current, current take the target, and busy drop, all at the same edge.
- R7: A request with an empty allowed set starts nothing and sets the flag of its path: req_path 0 or 3 (software/run) sets bit 0, 1 (sleep) sets bit 1, 2 (wakeup) sets bit 2.
- R8: Flags are sticky until a 1 is written to the same bit of flag_clr. When a flag is set and cleared in the same cycle, the set wins.
- R9: A request while busy is ignored: it neither changes the target nor raises a flag. seq_done while idle changes nothing.
- R10: While busy and without seq_done, the target stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| succ_maps | input | 256 | Successor map of each set point, 16 bits each |
| mode_masks | input | 64 | Allowed set-point mask of each CPU mode, 16 bits each |
| prio_lo | input | 32 | Priorities of set points 0 to 7, 4 bits each |
| prio_hi | input | 32 | Priorities of set points 8 to 15, 4 bits each |
| req_valid | input | 1 | Request strobe |
| req_mask | input | 16 | Set points acceptable to the requester |
| req_mode | input | 2 | CPU mode of the request |
| req_path | input | 2 | Request path: 0 software, 1 sleep, 2 wakeup, 3 software |
| flag_clr | input | 3 | Write-one-to-clear for the not-allowed flags |
| seq_done | input | 1 | Transition sequencer finished |
| seq_start | output | 1 | One-cycle pulse to start a transition |
| seq_target | output | 4 | Set point handed to the sequencer |
| busy | output | 1 | Transition in progress |
| cur_sp | output | 4 | Current set point |
| prev_sp | output | 4 | Previous set point |
| tgt_sp | output | 4 | Target set point |
| na_flags | output | 3 | Sticky not-allowed flags, one per request path |

## Verification
A rejected request can raise a flag in the very cycle that software writes 1 to clear that flag. The bench provokes this by presenting a request with an empty allowed set on the software path while pulsing bit 0 of flag_clr, together with a clear of another bit. The expected flag word is then the old flags with the cleared bits removed and the new bit set. A request that arrives while a transition is still busy is judged in the same way: target, busy and flags must be unchanged.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
  localparam int NUM_SP    = 16;
  localparam int SP_W      = $clog2(NUM_SP);
  localparam int PRIO_W    = 4;
  localparam int NUM_MODES = 4;
  localparam int MODE_W    = $clog2(NUM_MODES);
  localparam int NUM_PATHS = 3;
  localparam int WORD_W    = 32;
  localparam int PER_WORD  = WORD_W / PRIO_W;

  typedef logic [NUM_SP-1:0]    sp_map_t;
  typedef logic [SP_W-1:0]      sp_idx_t;
  typedef logic [PRIO_W-1:0]    prio_t;
  typedef logic [NUM_PATHS-1:0] path_vec_t;

  typedef enum logic [1:0] {
    PATH_SOFT  = 2'd0,
    PATH_SLEEP = 2'd1,
    PATH_WAKE  = 2'd2,
    PATH_ALT   = 2'd3
  } req_path_e;

  // priority of one set point out of the two packed words
  function automatic prio_t prio_of(input logic [WORD_W-1:0] lo,
                                    input logic [WORD_W-1:0] hi,
                                    input int unsigned idx);
    if (idx < PER_WORD) return lo[idx*PRIO_W +: PRIO_W];
    return hi[(idx-PER_WORD)*PRIO_W +: PRIO_W];
  endfunction

  // flag bit raised by a rejected request on a path
  function automatic path_vec_t path_bit(input req_path_e p);
    case (p)
      PATH_SLEEP: return 3'b010;
      PATH_WAKE:  return 3'b100;
      default:    return 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/sp_allow_calc.sv
module sp_allow_calc
  import sp_arb_pkg::*;
#(
  parameter int N     = NUM_SP,
  parameter int MODES = NUM_MODES,
  localparam int IW   = $clog2(N),
  localparam int MW   = $clog2(MODES)
) (
  input  logic [N*N-1:0]     succ_maps,
  input  logic [N*MODES-1:0] mode_masks,
  input  logic [IW-1:0]      cur_sp,
  input  logic [MW-1:0]      mode,
  input  logic [N-1:0]       want,
  output logic [N-1:0]       allowed
);
  logic [N-1:0] succ_row;
  logic [N-1:0] mode_row;

  always_comb begin
    succ_row = succ_maps[cur_sp*N +: N];
    mode_row = mode_masks[mode*N +: N];
    allowed  = succ_row & mode_row & want;
  end
endmodule

// File: rtl/sp_prio_pick.sv
module sp_prio_pick
  import sp_arb_pkg::*;
#(
  parameter int N  = NUM_SP,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]        allowed,
  input  logic [WORD_W-1:0]   prio_lo,
  input  logic [WORD_W-1:0]   prio_hi,
  output logic                found,
  output logic [IW-1:0]       winner
);
  prio_t best;

  // ascending scan with a strict compare keeps the lowest index on ties
  always_comb begin
    found  = 1'b0;
    winner = '0;
    best   = '0;
    for (int i = 0; i < N; i++) begin
      if (allowed[i] && (!found || prio_of(prio_lo, prio_hi, i) > best)) begin
        found  = 1'b1;
        winner = IW'(i);
        best   = prio_of(prio_lo, prio_hi, i);
      end
    end
  end
endmodule

// File: rtl/sp_flag_bank.sv
module sp_flag_bank #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flags
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 1'b0;
      else if (set_vec[g]) q <= 1'b1;
      else if (clr_vec[g]) q <= 1'b0;
    end
    assign flags[g] = q;

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr_vec[g]) |=> flags[g]);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> flags[g]);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !set_vec[g]) |=> !flags[g]);
  end
endmodule

// File: rtl/sp_arbiter.sv
module sp_arbiter
  import sp_arb_pkg::*;
#(
  parameter int N        = NUM_SP,
  parameter int MODES    = NUM_MODES,
  parameter int RESET_SP = 0,
  localparam int IW      = $clog2(N),
  localparam int MW      = $clog2(MODES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N*N-1:0]      succ_maps,
  input  logic [N*MODES-1:0]  mode_masks,
  input  logic [WORD_W-1:0]   prio_lo,
  input  logic [WORD_W-1:0]   prio_hi,
  input  logic                req_valid,
  input  logic [N-1:0]        req_mask,
  input  logic [MW-1:0]       req_mode,
  input  logic [1:0]          req_path,
  input  logic [NUM_PATHS-1:0] flag_clr,
  input  logic                seq_done,
  output logic                seq_start,
  output logic [IW-1:0]       seq_target,
  output logic                busy,
  output logic [IW-1:0]       cur_sp,
  output logic [IW-1:0]       prev_sp,
  output logic [IW-1:0]       tgt_sp,
  output logic [NUM_PATHS-1:0] na_flags
);
  // named internal events
  logic [N-1:0]         allowed_w;
  logic                 pick_found;
  logic [IW-1:0]        pick_idx;
  logic                 req_fire;
  logic                 accept_ev;
  logic                 reject_ev;
  logic                 commit_ev;
  logic [NUM_PATHS-1:0] flag_set;

  logic          busy_q, start_q;
  logic [IW-1:0] cur_q, prev_q, tgt_q;

  sp_allow_calc #(.N(N), .MODES(MODES)) u_allow (
    .succ_maps  (succ_maps),
    .mode_masks (mode_masks),
    .cur_sp     (cur_q),
    .mode       (req_mode),
    .want       (req_mask),
    .allowed    (allowed_w)
  );

  sp_prio_pick #(.N(N)) u_pick (
    .allowed (allowed_w),
    .prio_lo (prio_lo),
    .prio_hi (prio_hi),
    .found   (pick_found),
    .winner  (pick_idx)
  );

  assign req_fire  = req_valid && !busy_q;
  assign accept_ev = req_fire && pick_found;
  assign reject_ev = req_fire && !pick_found;
  assign commit_ev = busy_q && seq_done;
  assign flag_set  = reject_ev ? path_bit(req_path_e'(req_path)) : '0;

  sp_flag_bank #(.NF(NUM_PATHS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (flag_set),
    .clr_vec (flag_clr),
    .flags   (na_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cur_q   <= IW'(RESET_SP);
      prev_q  <= IW'(RESET_SP);
      tgt_q   <= IW'(RESET_SP);
    end else begin
      start_q <= accept_ev;
      if (accept_ev) begin
        busy_q <= 1'b1;
        tgt_q  <= pick_idx;
      end else if (commit_ev) begin
        busy_q <= 1'b0;
        prev_q <= cur_q;
        cur_q  <= tgt_q;
      end
    end
  end

  assign seq_start  = start_q;
  assign seq_target = tgt_q;
  assign busy       = busy_q;
  assign cur_sp     = cur_q;
  assign prev_sp    = prev_q;
  assign tgt_sp     = tgt_q;

  // R2: a winner must lie inside the allowed set built by the mask stage
  a_r2_winner_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> allowed_w[pick_idx]);
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> busy);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  a_r6_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> (!busy && cur_sp == $past(tgt_sp) && prev_sp == $past(cur_sp)));
  a_r7_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (!busy && !seq_start));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept_ev) |=> ($stable(cur_sp) && $stable(prev_sp)));
  a_r10_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> (busy && $stable(tgt_sp)));
endmodule

// File: tb/sp_arbiter_tb.sv
module sp_arbiter_tb;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] succ_maps;
  logic [63:0]  mode_masks;
  logic [31:0]  prio_lo, prio_hi;
  logic         req_valid = 1'b0;
  logic [15:0]  req_mask = '0;
  logic [1:0]   req_mode = '0;
  logic [1:0]   req_path = '0;
  logic [2:0]   flag_clr = '0;
  logic         seq_done = 1'b0;
  logic         seq_start, busy;
  logic [3:0]   seq_target, cur_sp, prev_sp, tgt_sp;
  logic [2:0]   na_flags;

  logic [15:0] succ [16];
  logic [15:0] mmask [4];
  logic [3:0]  prio [16];

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 16; i++) succ_maps[i*16 +: 16] = succ[i];
    for (int m = 0; m < 4; m++)  mode_masks[m*16 +: 16] = mmask[m];
    for (int i = 0; i < 8; i++) begin
      prio_lo[i*4 +: 4] = prio[i];
      prio_hi[i*4 +: 4] = prio[i+8];
    end
  end

  sp_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .succ_maps(succ_maps), .mode_masks(mode_masks),
    .prio_lo(prio_lo), .prio_hi(prio_hi), .req_valid(req_valid), .req_mask(req_mask),
    .req_mode(req_mode), .req_path(req_path), .flag_clr(flag_clr), .seq_done(seq_done),
    .seq_start(seq_start), .seq_target(seq_target), .busy(busy), .cur_sp(cur_sp),
    .prev_sp(prev_sp), .tgt_sp(tgt_sp), .na_flags(na_flags)
  );

  int checks = 0;
  int failures = 0;

  typedef struct {
    int    cur, prev, tgt, bsy, flg;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // model state
  int m_cur = 0, m_prev = 0, m_tgt = 0, m_busy = 0, m_flags = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // highest priority, lowest index on ties: descending scan with >=
  function automatic int ref_pick(input logic [15:0] a);
    int w = -1;
    int bp = -1;
    for (int i = 15; i >= 0; i--)
      if (a[i] && int'(prio[i]) >= bp) begin
        bp = int'(prio[i]);
        w = i;
      end
    return w;
  endfunction

  function automatic int path_flag(input logic [1:0] p);
    if (p == 2'd1) return 2;
    if (p == 2'd2) return 4;
    return 1;
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.cur = m_cur; e.prev = m_prev; e.tgt = m_tgt; e.bsy = m_busy; e.flg = m_flags; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: pops expected snapshots and compares against the ports
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(cur_sp) == e.cur,   e.tag, "cur_sp",   int'(cur_sp),   e.cur);
        chk(int'(prev_sp) == e.prev, e.tag, "prev_sp",  int'(prev_sp),  e.prev);
        chk(int'(tgt_sp) == e.tgt,   e.tag, "tgt_sp",   int'(tgt_sp),   e.tgt);
        chk(int'(busy) == e.bsy,     e.tag, "busy",     int'(busy),     e.bsy);
        chk(int'(na_flags) == e.flg, e.tag, "na_flags", int'(na_flags), e.flg);
      end
    end
  end

  task automatic do_req(input logic [15:0] mask, input logic [1:0] mode,
                        input logic [1:0] path, input logic [2:0] clr, input string tag);
    int w;
    bit acc;
    logic [15:0] a;
    a = mask & succ[m_cur] & mmask[mode];
    w = ref_pick(a);
    acc = (m_busy == 0) && (w >= 0);
    @(negedge clk);
    req_valid = 1'b1; req_mask = mask; req_mode = mode; req_path = path; flag_clr = clr;
    @(negedge clk);
    req_valid = 1'b0; flag_clr = '0;
    m_flags = m_flags & ~int'(clr);
    if (m_busy == 0 && w < 0) m_flags = m_flags | path_flag(path);
    if (acc) begin
      chk(seq_start == 1'b1, tag, "seq_start", int'(seq_start), 1);
      chk(int'(seq_target) == w, tag, "seq_target", int'(seq_target), w);
      m_busy = 1; m_tgt = w;
    end else begin
      chk(seq_start == 1'b0, tag, "seq_start idle", int'(seq_start), 0);
    end
    @(negedge clk);
    chk(seq_start == 1'b0, "R5", "seq_start pulse end", int'(seq_start), 0);
    push_exp(tag);
  endtask

  task automatic do_done(input string tag);
    @(negedge clk);
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
    if (m_busy == 1) begin
      m_prev = m_cur; m_cur = m_tgt; m_busy = 0;
    end
    push_exp(tag);
  endtask

  task automatic do_clr(input logic [2:0] clr, input string tag);
    @(negedge clk);
    flag_clr = clr;
    @(negedge clk);
    flag_clr = '0;
    m_flags = m_flags & ~int'(clr);
    push_exp(tag);
  endtask

  initial begin
    #(CLK_P*100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin succ[i] = 16'hFFFF; prio[i] = 4'd0; end
    for (int m = 0; m < 4; m++) mmask[m] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seq_start == 1'b0, "R1", "seq_start after reset", int'(seq_start), 0);
    push_exp("R1 reset state");

    // R4: equal priorities, lowest index wins
    do_req(16'h00F0, 2'd0, 2'd0, 3'b000, "R4 tie");
    do_done("R6 commit to 4");

    // R3: highest priority, one in the upper priority word
    prio[6] = 4'd9; prio[12] = 4'd12;
    do_req(16'h1040, 2'd0, 2'd0, 3'b000, "R3 priority");
    do_done("R6 commit to 12");

    // R2: successor map and mode mask narrow the choice
    succ[12] = 16'h0003; mmask[1] = 16'h0002;
    do_req(16'h0003, 2'd1, 2'd0, 3'b000, "R2 intersect");
    do_done("R6 commit to 1");

    // R7: empty allowed set on sleep and wakeup paths
    succ[1] = 16'h0100;
    do_req(16'h0001, 2'd0, 2'd1, 3'b000, "R7 sleep reject");
    do_req(16'h0001, 2'd0, 2'd2, 3'b000, "R7 wake reject");

    // R8: clear one bit, then set and clear in the same cycle
    do_clr(3'b010, "R8 clear");
    do_req(16'h0001, 2'd0, 2'd0, 3'b101, "R8 set wins");
    do_clr(3'b111, "R8 clear all");

    // R9: request while busy ignored, done while idle ignored
    do_req(16'h0100, 2'd0, 2'd0, 3'b000, "R5 start to 8");
    do_req(16'h0001, 2'd0, 2'd1, 3'b000, "R9 busy request");
    repeat (3) @(negedge clk);
    push_exp("R10 target hold");
    do_done("R6 commit to 8");
    do_done("R9 idle done");

    // R2: a mode whose mask is empty rejects everything (R7 software path)
    mmask[2] = 16'h0000;
    do_req(16'hFFFF, 2'd2, 2'd3, 3'b000, "R7 empty mode");

    // R4: tie at top priority across both words
    prio[3] = 4'd15; prio[11] = 4'd15;
    do_req(16'h0808, 2'd0, 2'd0, 3'b000, "R4 tie high");
    do_done("R6 commit to 3");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule